// File: doc/BRIEF.md
# Three-Phase Output Enable and Shoot-Through Guard

This block sits between a three-phase PWM generator and the output pads. It takes six raw drive levels, one positive and one negative leg per phase, and passes them to the pads. The pads are enabled only while the three-phase function is on and a software output-enable bit is set. Turning the pads off puts all six in high impedance, so an external driver stage sees no switching while the bridge is idle or has faulted.

A phase is in shoot-through when both of its legs are high in the same cycle. The block watches for this and records it in a sticky flag. If software has armed the guard, the same event also drops the output enable and all six pads go to high impedance. A falling edge on the active-low NMI input drops the output enable in the same way. Once tripped, the pads stay off until software writes the output enable to 1 again.

Control writes take effect only while a separate unlock input is high. The flag cannot be set by software. Software may clear it only in a write that also disarms the guard.

Top module: `ph3_shoot_guard`

## Requirements
- R1: After reset, oe_stat, flag and the internal guard bit are 0, and pad_oe is all zeros.
- R2: pad_oe is all ones when func_en and oe_stat are both 1, and all zeros otherwise. pad_do equals drv_in in every cycle.
- R3: A write (wr_en high) made while unlock is low changes neither oe_stat, flag nor the guard bit.
- R4: An accepted write loads wr_oe into oe_stat and wr_guard into the guard bit. Both are visible after the next clock edge.
- R5: drv_in bit 2k is the positive leg and bit 2k+1 the negative leg of phase k (0=U, 1=V, 2=W). If func_en is 1 and any pair has both bits high in a cycle, flag is 1 after that clock edge. With func_en at 0, the pairs are not inspected.
- R6: A shoot-through cycle with the guard bit at 1 clears oe_stat at that edge. With the guard bit at 0, oe_stat is unaffected.
- R7: Writing wr_flag=1 never sets flag. flag rises only from a shoot-through cycle.
- R8: While flag is 1, a write with wr_flag=0 and wr_guard=1 is ignored entirely. A write with wr_flag=0 and wr_guard=0 clears flag.
- R9: A high-to-low change on nmi_n clears oe_stat at the third rising clock edge after the change. This allows two synchroniser stages and one edge stage. A low-to-high change has no effect.
- R10: If a hardware clear of oe_stat (guarded shoot-through or NMI edge) falls in the same cycle as a write of wr_oe=1, the clear wins. A shoot-through cycle sets flag even when the same cycle carries a write that clears flag.
- R11: After a trip, oe_stat stays 0 until an accepted write with wr_oe=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_en | input | 1 | Three-phase function enable |
| unlock | input | 1 | Write-protect release; writes accepted only when high |
| wr_en | input | 1 | Control write strobe |
| wr_oe | input | 1 | Write data: output enable |
| wr_guard | input | 1 | Write data: shoot-through guard arm |
| wr_flag | input | 1 | Write data: detect flag (0 clears, 1 no effect) |
| nmi_n | input | 1 | Asynchronous active-low NMI level |
| drv_in | input | 6 | Raw drive legs {W-,W+,V-,V+,U-,U+} |
| pad_oe | output | 6 | Per-pad drive enable; 0 means high impedance |
| pad_do | output | 6 | Per-pad data |
| flag | output | 1 | Sticky shoot-through detect flag |
| oe_stat | output | 1 | Output enable status |

## Verification
Register results appear one edge after their cause. Accepted writes, shoot-through detection and the guard trip all update flag and oe_stat one edge after the cycle that carries the stimulus. pad_oe then follows oe_stat in the same cycle, and pad_do follows drv_in combinationally. The NMI path has three stages, so oe_stat is checked still high two edges after the falling edge and low after the third. The bench changes inputs a short delay after a rising edge and reads outputs just before the next rising edge. Every comparison is therefore made in the cycle where the result is due.

// File: rtl/ph3_shoot_guard.sv
module ph3_shoot_guard #(
  parameter int NPH = 3,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 func_en,
  input  logic                 unlock,
  input  logic                 wr_en,
  input  logic                 wr_oe,
  input  logic                 wr_guard,
  input  logic                 wr_flag,
  input  logic                 nmi_n,
  input  logic [2*NPH-1:0]     drv_in,
  output logic [2*NPH-1:0]     pad_oe,
  output logic [2*NPH-1:0]     pad_do,
  output logic                 flag,
  output logic                 oe_stat
);
  localparam int NPIN = 2 * NPH;
  localparam int NSR  = SYNC + 1;

  logic [NPH-1:0] pair_hit;
  logic [NSR-1:0] nmi_sr;
  logic conc, nmi_fall, wr_ok, hw_off;
  logic oe_q, guard_q, flag_q;

  for (genvar k = 0; k < NPH; k++) begin : g_pair
    assign pair_hit[k] = drv_in[2*k] & drv_in[2*k+1];
  end

  assign conc = func_en & (|pair_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nmi_sr <= '1;
    else        nmi_sr <= {nmi_sr[NSR-2:0], nmi_n};

  assign nmi_fall = nmi_sr[NSR-1] & ~nmi_sr[NSR-2];

  assign wr_ok  = wr_en & unlock & ~(flag_q & ~wr_flag & wr_guard);
  assign hw_off = (conc & guard_q) | nmi_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oe_q    <= 1'b0;
      guard_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (hw_off)     oe_q <= 1'b0;
      else if (wr_ok) oe_q <= wr_oe;
      if (wr_ok) guard_q <= wr_guard;
      if (conc)                  flag_q <= 1'b1;
      else if (wr_ok && !wr_flag) flag_q <= 1'b0;
    end

  assign pad_oe  = {NPIN{func_en & oe_q}};
  assign pad_do  = drv_in;
  assign flag    = flag_q;
  assign oe_stat = oe_q;
endmodule

module ph3_shoot_guard_chk #(
  parameter int NPH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             func_en,
  input logic             unlock,
  input logic             wr_en,
  input logic [2*NPH-1:0] drv_in,
  input logic [2*NPH-1:0] pad_oe,
  input logic             flag,
  input logic             oe_stat,
  input logic             guard_q,
  input logic             nmi_fall
);
  logic hit_c;
  always_comb begin
    hit_c = 1'b0;
    for (int k = 0; k < NPH; k++)
      if (drv_in[2*k] && drv_in[2*k+1]) hit_c = 1'b1;
  end

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en && hit_c) |=> flag);
  p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(func_en && hit_c));
  p_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en && hit_c && guard_q) |=> !oe_stat);
  p_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fall |=> !oe_stat);
  p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && unlock) && !(func_en && hit_c) && !nmi_fall) |=> ($stable(oe_stat) && $stable(flag)));
  p_reenable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_stat) |-> $past(wr_en && unlock));
  p_pad_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_stat) |-> (pad_oe == '0));
endmodule

bind ph3_shoot_guard ph3_shoot_guard_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .func_en(func_en), .unlock(unlock), .wr_en(wr_en),
  .drv_in(drv_in), .pad_oe(pad_oe), .flag(flag), .oe_stat(oe_stat),
  .guard_q(guard_q), .nmi_fall(nmi_fall)
);

// File: tb/ph3_shoot_guard_tb.sv
module ph3_shoot_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic func_en = 1'b0, unlock = 1'b0, wr_en = 1'b0;
  logic wr_oe = 1'b0, wr_guard = 1'b0, wr_flag = 1'b0, nmi_n = 1'b1;
  logic [5:0] drv_in = '0;
  logic [5:0] pad_oe, pad_do;
  logic flag, oe_stat;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ph3_shoot_guard u_dut (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .unlock(unlock), .wr_en(wr_en),
    .wr_oe(wr_oe), .wr_guard(wr_guard), .wr_flag(wr_flag), .nmi_n(nmi_n),
    .drv_in(drv_in), .pad_oe(pad_oe), .pad_do(pad_do), .flag(flag), .oe_stat(oe_stat)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic oe, input logic g, input logic f, input logic unl);
    wr_en = 1'b1; unlock = unl; wr_oe = oe; wr_guard = g; wr_flag = f;
    tick();
    wr_en = 1'b0; unlock = 1'b0;
  endtask

  function automatic logic hit(input logic [5:0] d);
    return (d[0] & d[1]) | (d[2] & d[3]) | (d[4] & d[5]);
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk(oe_stat == 0 && flag == 0 && pad_oe == 0, "R1 reset state", {oe_stat, flag, pad_oe}, 0);
    rst_n = 1'b1;
    func_en = 1'b1;
    tick();
    chk(pad_oe == 0, "R1 pads off after reset", pad_oe, 0);

    wr(1, 0, 1, 0);
    chk(oe_stat == 0, "R3 locked write ignored", oe_stat, 0);
    wr(1, 0, 1, 1);
    chk(oe_stat == 1, "R4 write oe=1", oe_stat, 1);
    chk(pad_oe == 6'h3f, "R2 pads driven", pad_oe, 6'h3f);
    func_en = 1'b0; #1;
    chk(pad_oe == 0, "R2 func off pads hi-z", pad_oe, 0);
    func_en = 1'b1;
    wr(0, 0, 1, 0);
    chk(oe_stat == 1, "R3 locked clear ignored", oe_stat, 1);
    wr(0, 0, 1, 1);
    chk(oe_stat == 0 && pad_oe == 0, "R4 write oe=0", {oe_stat, pad_oe}, 0);

    for (int fe = 0; fe < 2; fe++)
      for (int g = 0; g < 2; g++)
        for (int d = 0; d < 64; d++) begin
          logic eh;
          func_en = 1'b1; drv_in = '0;
          wr(1, 0, 0, 1);
          wr(1, g[0], 1, 1);
          chk(flag == 0, "R7 flag write 1 no set", flag, 0);
          func_en = fe[0]; drv_in = d[5:0];
          #1;
          chk(pad_do == d[5:0], "R2 pad data", pad_do, d);
          tick();
          eh = fe[0] & hit(d[5:0]);
          chk(flag == eh, "R5 detect", flag, eh);
          chk(oe_stat == !(eh & g[0]), "R6 guard trip", oe_stat, !(eh & g[0]));
          chk(pad_oe == {6{fe[0] & !(eh & g[0])}}, "R2 pad enable", pad_oe, {6{fe[0] & !(eh & g[0])}});
        end

    func_en = 1'b1; drv_in = '0;
    wr(1, 0, 0, 1);
    wr(1, 1, 1, 1);
    drv_in = 6'b001100; tick(); drv_in = '0;
    chk(flag == 1 && oe_stat == 0, "R6 tripped", {flag, oe_stat}, 2);
    tick(); tick();
    chk(oe_stat == 0, "R11 stays off", oe_stat, 0);
    wr(1, 1, 0, 1);
    chk(flag == 1 && oe_stat == 0, "R8 bad clear ignored", {flag, oe_stat}, 2);
    wr(1, 0, 0, 1);
    chk(flag == 0 && oe_stat == 1, "R8 clear accepted R11 re-enable", {flag, oe_stat}, 1);

    wr(1, 1, 1, 1);
    drv_in = 6'b110000; wr_en = 1; unlock = 1; wr_oe = 1; wr_guard = 1; wr_flag = 1;
    tick(); wr_en = 0; unlock = 0; drv_in = '0;
    chk(oe_stat == 0, "R10 trip beats write", oe_stat, 0);
    wr(1, 0, 0, 1);
    drv_in = 6'b000011; wr_en = 1; unlock = 1; wr_oe = 1; wr_guard = 0; wr_flag = 0;
    tick(); wr_en = 0; unlock = 0; drv_in = '0;
    chk(flag == 1 && oe_stat == 1, "R10 detect beats flag clear", {flag, oe_stat}, 3);
    wr(1, 0, 0, 1);

    nmi_n = 1'b0;
    tick(); tick();
    chk(oe_stat == 1, "R9 nmi not yet", oe_stat, 1);
    tick();
    chk(oe_stat == 0, "R9 nmi cleared", oe_stat, 0);
    wr(1, 0, 0, 1);
    nmi_n = 1'b1; tick(); tick(); tick(); tick();
    chk(oe_stat == 1, "R9 rising nmi no effect", oe_stat, 1);
    nmi_n = 1'b0;
    tick(); tick();
    wr_en = 1; unlock = 1; wr_oe = 1; wr_guard = 0; wr_flag = 1;
    tick(); wr_en = 0; unlock = 0;
    chk(oe_stat == 0, "R10 nmi beats write", oe_stat, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule